// File: doc/BRIEF.md
# Range-Doppler Corner-Turn Buffer

This block sits between a streaming range FFT and a streaming Doppler FFT in a single-channel FMCW receiver. Range-FFT results arrive one complex sample per clock, chirp after chirp. Each sample carries a packet-start marker and a chirp-start marker. The block gathers one whole packet, which is one coherent processing interval. It then streams that packet back out transposed. All chirps of range bin 0 come first, in chirp order, then all chirps of bin 1, and so on. A Doppler FFT can therefore run along each bin without any further reordering.

Storage is split into two packet-sized banks that swap roles on every packet. The next packet can be written into one bank while the previous packet is read out of the other, so a steady stream flows without gaps. Each input part is 16-bit Q15. On the way out it becomes 32-bit Q31: the sign is kept and the value is placed in the upper half, with zeros below. Packet-start and chirp-start markers that arrive at the wrong position are treated as framing faults. A faulty partial packet is discarded and a sticky error flag is raised.

The size is set by parameters. A production configuration uses 512 range bins and 256 chirps per packet. The default parameters are small, so the register-array memory stays compact.

Top module: `cturn_buffer`

## Requirements
- R1: Let NBINS be the number of range bins and NCHIRPS the number of chirps per packet. Output beat k of a packet (k counted from 0) carries the input sample of range bin k / NCHIRPS and chirp k mod NCHIRPS of that same packet. Input samples are numbered chirp-major: sample j of a packet is bin j mod NBINS of chirp j / NBINS.
- R2: Each output part equals the matching 16-bit input part placed in bits 31:16, with bits 15:0 zero. A negative input therefore gives a negative output.
- R3: While a complete packet is stored and out_ready is held high, the packet leaves in exactly NBINS*NCHIRPS consecutive cycles.
- R4: A packet can be written while the other bank is being read, at one sample per cycle. in_ready goes low only when both banks hold a complete, unread packet.
- R5: out_valid is low whenever no complete packet is stored.
- R6: out_bin_first is high on the first beat of each range bin (chirp 0). out_last is high only on the final beat of a packet.
- R7: A packet-start marker that arrives while a packet is partly written sets frame_err, which stays set until reset. The partial packet is dropped, and the marked sample becomes sample 0 of a new packet.
- R8: A chirp-start marker on a sample that is not bin 0 of a chirp, and that has no packet-start marker, sets frame_err. The partial packet is dropped, and the writer then waits for the next packet-start marker.
- R9: While the writer is waiting for a packet start, samples without a packet-start marker are accepted and dropped. They do not appear in any output and do not set frame_err.
- R10: While out_valid is high and out_ready is low, out_valid and all output data and flags keep their values into the next cycle.
- R11: After reset, out_valid is low, in_ready is high and frame_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts the input sample |
| in_re | input | IN_W | Range-FFT real part, Q15 |
| in_im | input | IN_W | Range-FFT imaginary part, Q15 |
| in_chirp_start | input | 1 | Sample is bin 0 of a chirp |
| in_pkt_start | input | 1 | Sample is the first of a packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_re | output | OUT_W | Real part, Q31 |
| out_im | output | OUT_W | Imaginary part, Q31 |
| out_bin_first | output | 1 | First beat of a range bin |
| out_last | output | 1 | Final beat of the packet |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The bench goes after the transpose order with distinct, sign-varied values in every cell. A design that swaps the inner and outer counters, or mixes chirp and bin in its address, delivers values out of order, and every misplaced beat is caught by the scoreboard. The bench overlaps the write of one packet with the read of the previous one. It then fills both banks against a stalled output. A bank-swap or full-flag error shows up here as a stall during streaming, a lost or repeated packet, or in_ready that stays high when both banks are full. Early packet starts, misplaced chirp starts and stray samples outside a packet are all sent. A design that lets any of them leak into a stored packet produces output that belongs to no complete packet. Random output back-pressure exposes data that changes while the output is stalled.

// File: rtl/cturn_pkg.sv
package cturn_pkg;

  // Writer framing state: hunting for a packet start, or filling a bank.
  typedef enum logic {
    WR_HUNT = 1'b0,
    WR_FILL = 1'b1
  } wr_state_e;

  // Linear cell index of (row, column) in a row-major array of ncols columns.
  function automatic int unsigned cell_index(int unsigned row, int unsigned col,
                                             int unsigned ncols);
    return row * ncols + col;
  endfunction

endpackage

// File: rtl/cturn_wr_ctrl.sv
module cturn_wr_ctrl
  import cturn_pkg::*;
#(
  parameter int NBINS   = 16,
  parameter int NCHIRPS = 8,
  parameter int ADDR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_pkt_start,
  input  logic              in_chirp_start,
  input  logic [1:0]        bank_full,
  output logic              in_ready,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              pkt_done,
  output logic              frame_err
);

  localparam int BIN_W = $clog2(NBINS);
  localparam int CHP_W = $clog2(NCHIRPS);
  localparam logic [BIN_W-1:0] BIN_LAST = BIN_W'(NBINS - 1);
  localparam logic [CHP_W-1:0] CHP_LAST = CHP_W'(NCHIRPS - 1);

  wr_state_e        st_q, st_n;
  logic [BIN_W-1:0] bin_q, bin_n, pos_bin;
  logic [CHP_W-1:0] chirp_q, chirp_n, pos_chirp;
  logic             bank_q, bank_n;
  logic             err_q, err_n;
  logic             accept;

  assign in_ready = ~bank_full[bank_q];
  assign accept   = in_valid & in_ready;

  always_comb begin
    st_n      = st_q;
    bin_n     = bin_q;
    chirp_n   = chirp_q;
    bank_n    = bank_q;
    err_n     = err_q;
    pos_bin   = bin_q;
    pos_chirp = chirp_q;
    wr_en     = 1'b0;
    pkt_done  = 1'b0;

    if (accept) begin
      if (in_pkt_start) begin
        if (st_q == WR_FILL) err_n = 1'b1;
        pos_bin   = '0;
        pos_chirp = '0;
        wr_en     = 1'b1;
      end else if (st_q == WR_FILL) begin
        if (in_chirp_start && (bin_q != '0)) begin
          err_n   = 1'b1;
          st_n    = WR_HUNT;
          bin_n   = '0;
          chirp_n = '0;
        end else begin
          wr_en = 1'b1;
        end
      end
    end

    if (wr_en) begin
      st_n = WR_FILL;
      if (pos_bin == BIN_LAST) begin
        bin_n = '0;
        if (pos_chirp == CHP_LAST) begin
          chirp_n  = '0;
          st_n     = WR_HUNT;
          pkt_done = 1'b1;
          bank_n   = ~bank_q;
        end else begin
          chirp_n = pos_chirp + 1'b1;
        end
      end else begin
        bin_n   = pos_bin + 1'b1;
        chirp_n = pos_chirp;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WR_HUNT;
      bin_q   <= '0;
      chirp_q <= '0;
      bank_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      bin_q   <= bin_n;
      chirp_q <= chirp_n;
      bank_q  <= bank_n;
      err_q   <= err_n;
    end
  end

  assign wr_addr   = ADDR_W'(cell_index(int'(pos_chirp), int'(pos_bin), NBINS));
  assign wr_bank   = bank_q;
  assign frame_err = err_q;

endmodule

// File: rtl/cturn_rd_ctrl.sv
module cturn_rd_ctrl
  import cturn_pkg::*;
#(
  parameter int NBINS   = 16,
  parameter int NCHIRPS = 8,
  parameter int ADDR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bank_full,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              rd_bank,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              bin_first,
  output logic              pkt_last,
  output logic              pkt_free
);

  localparam int BIN_W = $clog2(NBINS);
  localparam int CHP_W = $clog2(NCHIRPS);
  localparam logic [BIN_W-1:0] BIN_LAST = BIN_W'(NBINS - 1);
  localparam logic [CHP_W-1:0] CHP_LAST = CHP_W'(NCHIRPS - 1);

  logic [BIN_W-1:0] bin_q, bin_n;
  logic [CHP_W-1:0] chirp_q, chirp_n;
  logic             bank_q, bank_n;
  logic             fire;

  assign out_valid = bank_full[bank_q];
  assign fire      = out_valid & out_ready;
  assign bin_first = (chirp_q == '0);
  assign pkt_last  = (chirp_q == CHP_LAST) && (bin_q == BIN_LAST);

  always_comb begin
    bin_n    = bin_q;
    chirp_n  = chirp_q;
    bank_n   = bank_q;
    pkt_free = 1'b0;
    if (fire) begin
      if (chirp_q == CHP_LAST) begin
        chirp_n = '0;
        if (bin_q == BIN_LAST) begin
          bin_n    = '0;
          bank_n   = ~bank_q;
          pkt_free = 1'b1;
        end else begin
          bin_n = bin_q + 1'b1;
        end
      end else begin
        chirp_n = chirp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q   <= '0;
      chirp_q <= '0;
      bank_q  <= 1'b0;
    end else begin
      bin_q   <= bin_n;
      chirp_q <= chirp_n;
      bank_q  <= bank_n;
    end
  end

  assign rd_addr = ADDR_W'(cell_index(int'(chirp_q), int'(bin_q), NBINS));
  assign rd_bank = bank_q;

endmodule

// File: rtl/cturn_bank_mem.sv
module cturn_bank_mem #(
  parameter int DEPTH  = 128,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 7,
  parameter int NBANKS = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] bank_rd [NBANKS];

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    logic [WORD_W-1:0] cells [DEPTH];
    logic              bank_we;

    assign bank_we = wr_en && (wr_bank == 1'(g));

    always_ff @(posedge clk) begin
      if (bank_we) cells[wr_addr] <= wr_data;
    end

    assign bank_rd[g] = cells[rd_addr];
  end

  assign rd_data = bank_rd[rd_bank];

endmodule

// File: rtl/cturn_widen.sv
module cturn_widen #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  narrow,
  output logic [OUT_W-1:0] wide
);

  localparam int PAD_W = OUT_W - IN_W;

  // Keeping the sign bit at the top and padding below scales Q15 into Q31.
  assign wide = {narrow, {PAD_W{1'b0}}};

endmodule

// File: rtl/cturn_buffer.sv
module cturn_buffer #(
  parameter int NBINS   = 16,
  parameter int NCHIRPS = 8,
  parameter int IN_W    = 16,
  parameter int OUT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_re,
  input  logic [IN_W-1:0]  in_im,
  input  logic             in_chirp_start,
  input  logic             in_pkt_start,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_re,
  output logic [OUT_W-1:0] out_im,
  output logic             out_bin_first,
  output logic             out_last,
  output logic             frame_err
);

  localparam int DEPTH  = NBINS * NCHIRPS;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int WORD_W = 2 * IN_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [1:0]        full_q, full_n;
  logic              wr_en, wr_bank, pkt_done;
  logic [ADDR_W-1:0] wr_addr;
  logic              rd_bank, pkt_free;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cturn_wr_ctrl #(
    .NBINS(NBINS), .NCHIRPS(NCHIRPS), .ADDR_W(ADDR_W)
  ) u_wr (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(in_valid), .in_pkt_start(in_pkt_start), .in_chirp_start(in_chirp_start),
    .bank_full(full_q), .in_ready(in_ready),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .pkt_done(pkt_done), .frame_err(frame_err)
  );

  cturn_rd_ctrl #(
    .NBINS(NBINS), .NCHIRPS(NCHIRPS), .ADDR_W(ADDR_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_int_n),
    .bank_full(full_q), .out_ready(out_ready), .out_valid(out_valid),
    .rd_bank(rd_bank), .rd_addr(rd_addr),
    .bin_first(out_bin_first), .pkt_last(out_last), .pkt_free(pkt_free)
  );

  cturn_bank_mem #(
    .DEPTH(DEPTH), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .NBANKS(2)
  ) u_mem (
    .clk(clk),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data({in_re, in_im}),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_word)
  );

  cturn_widen #(.IN_W(IN_W), .OUT_W(OUT_W)) u_widen_re (
    .narrow(rd_word[WORD_W-1:IN_W]), .wide(out_re)
  );

  cturn_widen #(.IN_W(IN_W), .OUT_W(OUT_W)) u_widen_im (
    .narrow(rd_word[IN_W-1:0]), .wide(out_im)
  );

  // A bank becomes full when its last sample is written and empty when its last beat leaves.
  always_comb begin
    full_n = full_q;
    if (pkt_done) full_n[wr_bank] = 1'b1;
    if (pkt_free) full_n[rd_bank] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) full_q <= 2'b00;
    else            full_q <= full_n;
  end

endmodule

// File: rtl/cturn_buffer_chk.sv
module cturn_buffer_chk #(
  parameter int NBINS   = 16,
  parameter int NCHIRPS = 8,
  parameter int IN_W    = 16,
  parameter int OUT_W   = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_re,
  input logic [OUT_W-1:0] out_im,
  input logic             out_bin_first,
  input logic             out_last,
  input logic             frame_err
);

  localparam int TOTAL  = NBINS * NCHIRPS;
  localparam int BEAT_W = $clog2(TOTAL);
  localparam int PAD_W  = OUT_W - IN_W;

  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else if (out_valid && out_ready) begin
      if (beat_q == BEAT_W'(TOTAL - 1)) beat_q <= '0;
      else                              beat_q <= beat_q + 1'b1;
    end
  end

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)
                                   && $stable(out_bin_first) && $stable(out_last)));

  p_sticky_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  p_backpressure_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  p_widen_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_re[PAD_W-1:0] == '0) && (out_im[PAD_W-1:0] == '0));

  p_bin_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bin_first == ((int'(beat_q) % NCHIRPS) == 0)));

  p_last_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (beat_q == BEAT_W'(TOTAL - 1))));

endmodule

bind cturn_buffer cturn_buffer_chk #(
  .NBINS(NBINS), .NCHIRPS(NCHIRPS), .IN_W(IN_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_re(out_re), .out_im(out_im),
  .out_bin_first(out_bin_first), .out_last(out_last), .frame_err(frame_err)
);

// File: tb/cturn_buffer_test.sv
`timescale 1ns/1ps
module cturn_buffer_test;

  localparam int NB  = 16;
  localparam int NC  = 8;
  localparam int TOT = NB * NC;
  localparam int IW  = 16;
  localparam int OW  = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, in_chirp_start, in_pkt_start;
  logic [IW-1:0] in_re, in_im;
  logic          out_valid, out_ready, out_bin_first, out_last, frame_err;
  logic [OW-1:0] out_re, out_im;

  always #2 clk = ~clk;

  cturn_buffer #(.NBINS(NB), .NCHIRPS(NC), .IN_W(IW), .OUT_W(OW)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .in_chirp_start(in_chirp_start), .in_pkt_start(in_pkt_start),
    .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im),
    .out_bin_first(out_bin_first), .out_last(out_last), .frame_err(frame_err)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc   = 0;
  bit  reported = 0;
  int  rdy_mode = 0;
  logic [7:0] lfsr = 8'h5a;
  logic [65:0] exp_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [65:0] act, input logic [65:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  function automatic logic [IW-1:0] gen_re(int p, int c, int b);
    int v;
    v = (p * 7919 + c * 613 + b * 97) * 37;
    return IW'(v);
  endfunction

  function automatic logic [IW-1:0] gen_im(int p, int c, int b);
    int v;
    v = p * 1201 - c * 311 + b * 53 + 36864;
    return IW'(v);
  endfunction

  // Expected output order of a complete packet: bin outer, chirp inner (R1, R2, R6).
  task automatic push_exp(input int p);
    for (int b = 0; b < NB; b++) begin
      for (int c = 0; c < NC; c++) begin
        exp_q.push_back({gen_re(p, c, b), 16'h0000, gen_im(p, c, b), 16'h0000,
                         (c == 0), (b == NB - 1 && c == NC - 1)});
      end
    end
  endtask

  // Output ready pattern, changed just after each rising edge.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = 1'b0;
      default: out_ready = lfsr[0] | lfsr[2];
    endcase
  end

  // Scoreboard monitor, sampling at the falling edge.
  logic        stall_q = 1'b0;
  logic [65:0] held;
  always @(negedge clk) begin
    logic [65:0] act;
    logic [65:0] e;
    act = {out_re, out_im, out_bin_first, out_last};
    if (!rst_n) begin
      stall_q = 1'b0;
    end else begin
      if (stall_q)
        check(out_valid && act == held, "R10", "stalled output changed", act, held);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "output with nothing expected", act, '0);
        end else begin
          e = exp_q.pop_front();
          check(act == e, "R1 R2 R6", "output beat", act, e);
        end
      end
      stall_q = out_valid && !out_ready;
      held    = act;
    end
  end

  task automatic to_drive();
    @(posedge clk);
    #1;
  endtask

  task automatic drive_beat(input logic [IW-1:0] re, input logic [IW-1:0] im,
                            input bit ps, input bit cs);
    in_valid       = 1'b1;
    in_re          = re;
    in_im          = im;
    in_pkt_start   = ps;
    in_chirp_start = cs;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    to_drive();
    in_valid       = 1'b0;
    in_pkt_start   = 1'b0;
    in_chirp_start = 1'b0;
  endtask

  task automatic send_partial(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      drive_beat(gen_re(p, k / NB, k % NB), gen_im(p, k / NB, k % NB),
                 (k == 0), (k % NB == 0));
    end
  endtask

  task automatic send_packet(input int p, output int cycles);
    int t0;
    t0 = cyc;
    send_partial(p, TOT);
    cycles = cyc - t0;
    push_exp(p);
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 5000) begin
      @(posedge clk);
      t++;
    end
    repeat (3) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R1", "packet not fully delivered", 66'(exp_q.size()), '0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after reset", 66'(out_valid), '0);
    check(in_ready == 1'b1, "R11", "in_ready after reset", 66'(in_ready), 66'(1));
    check(frame_err == 1'b0, "R11", "frame_err after reset", 66'(frame_err), '0);
    to_drive();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int cyc_a;
    int cyc_b;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_re = '0;
    in_im = '0;
    in_pkt_start = 1'b0;
    in_chirp_start = 1'b0;
    out_ready = 1'b0;
    do_reset();

    // R3, R4: two packets back to back while the first one streams out.
    fork
      begin
        send_packet(0, cyc_a);
        send_packet(1, cyc_b);
        check(cyc_a == TOT, "R4", "write cycles, packet 0", 66'(cyc_a), 66'(TOT));
        check(cyc_b == TOT, "R4", "write cycles during readout", 66'(cyc_b), 66'(TOT));
      end
      begin
        int el;
        do @(negedge clk); while (!out_valid);
        el = 1;
        while (!(out_valid && out_ready && out_last)) begin
          @(negedge clk);
          el++;
        end
        check(el == TOT, "R3", "readout cycles", 66'(el), 66'(TOT));
      end
    join
    drain();

    // R9: stray samples outside a packet are dropped.
    drive_beat(16'h1111, 16'h2222, 1'b0, 1'b0);
    drive_beat(16'h3333, 16'h4444, 1'b0, 1'b1);
    drive_beat(16'h5555, 16'h6666, 1'b0, 1'b0);
    send_packet(2, cyc_a);
    drain();
    @(negedge clk);
    check(frame_err == 1'b0, "R9", "frame_err after stray samples", 66'(frame_err), '0);
    to_drive();

    // R5, R7: a partial packet, then an early packet start.
    send_partial(3, 40);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R5", "out_valid with partial packet", 66'(out_valid), '0);
    to_drive();
    send_packet(4, cyc_a);
    @(negedge clk);
    check(frame_err == 1'b1, "R7", "frame_err after early start", 66'(frame_err), 66'(1));
    to_drive();
    drain();
    @(negedge clk);
    check(frame_err == 1'b1, "R7", "frame_err stays set", 66'(frame_err), 66'(1));
    to_drive();

    // R8: misplaced chirp start, then the writer waits for a packet start.
    do_reset();
    send_partial(9, 3);
    drive_beat(16'h7abc, 16'h8def, 1'b0, 1'b1);
    for (int k = 0; k < 5; k++) drive_beat(IW'(k * 4097), IW'(k * 771), 1'b0, 1'b0);
    @(negedge clk);
    check(frame_err == 1'b1, "R8", "frame_err after misplaced chirp start", 66'(frame_err), 66'(1));
    check(out_valid == 1'b0, "R8", "no output from dropped data", 66'(out_valid), '0);
    to_drive();
    send_packet(5, cyc_a);
    drain();

    // R4, R10: both banks filled against a stalled output, then random back-pressure.
    rdy_mode = 1;
    to_drive();
    send_packet(6, cyc_a);
    send_packet(7, cyc_b);
    @(negedge clk);
    check(in_ready == 1'b0, "R4", "in_ready with both banks full", 66'(in_ready), '0);
    check(out_valid == 1'b1, "R4", "out_valid with both banks full", 66'(out_valid), 66'(1));
    to_drive();
    rdy_mode = 2;
    drain();
    send_packet(8, cyc_a);
    drain();
    @(negedge clk);
    check(out_valid == 1'b0, "R5", "out_valid once drained", 66'(out_valid), '0);

    report();
    $finish;
  end

endmodule